// File: doc/BRIEF.md
# Out-of-Order Issue Window with Wakeup and Oldest-First Select

This block is the scheduling core of an out-of-order pipeline. Renamed instructions are written into a window of entries. Each entry holds two source tags, a ready flag for each source, a destination tag and an age stamp. Every cycle, result tags arrive on a set of external broadcast buses. Each waiting entry compares both of its source tags against every bus, and a hit on any bus marks that source as available. An entry that has both sources available requests issue. A select tree then hands at most one requesting entry to each functional unit, oldest first.

An issued entry is released at the same edge that loads the issue register of its unit. The destination tag in that register is also used as an extra wakeup bus for the cycle in which it is visible. A dependent can therefore issue in the very next cycle. Each entry runs a three-state machine. `ENT_FREE` is empty and goes to `ENT_WAIT` or `ENT_READY` on allocation. `ENT_WAIT` holds at least one missing source; it goes to `ENT_READY` when the last source arrives, or to `ENT_FREE` when granted. `ENT_READY` holds both sources and goes to `ENT_FREE` when granted. Wakeup hits in the current cycle count toward the request without waiting for the state to change.

The select tree is built from 4-input arbiter cells. Each cell passes its oldest request and that request's age toward the root, and routes the returning grant to the winning child. Unit 0 uses the raw requests. Each further unit uses the requests with all earlier grants removed. Dispatch places a new entry in the lowest-numbered free slot.

Top module: `issue_window`

## Requirements
- R1: During and right after reset, no `iss_valid` bit is set and `win_full` is low.
- R2: An entry dispatched with both sources marked ready, captured at edge E and with nothing older competing, appears on unit 0 after edge E+1. The unit-0 slices of `iss_dst`, `iss_src0`, `iss_src1` and `iss_age` carry that entry's fields, and the entry does not appear again.
- R3: A broadcast with its `bc_valid` bit high, whose tag equals a waiting source tag, marks that source ready. This holds on any of the buses. If the broadcast supplies an entry's last missing source in cycle C, the entry issues at the end of cycle C. A tag on a bus whose valid bit is low has no effect.
- R4: An entry with only one source ready never issues.
- R5: A valid broadcast in the same cycle as the dispatch of a matching source tag marks that source ready at dispatch.
- R6: Each unit receives at most one entry per cycle, and no entry goes to two units. When at least as many entries are ready as there are units, every unit issues.
- R7: Unit 0 gets the ready entry with the smallest `disp_age` value, and unit 1 gets the next smallest. Equal ages go to the lower slot. Within one cycle, the age on unit 0 is never larger than the age on unit 1.
- R8: The destination tag shown on a valid issue output acts as a wakeup broadcast in the same cycle. A consumer of that tag issues one cycle after its producer.
- R9: `win_full` is high exactly when every slot is occupied. A dispatch while `win_full` is high is dropped. An issued slot is free at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch strobe for one instruction |
| disp_src0 | input | TAG_W | First source tag |
| disp_rdy0 | input | 1 | First source already available |
| disp_src1 | input | TAG_W | Second source tag |
| disp_rdy1 | input | 1 | Second source already available |
| disp_dst | input | TAG_W | Destination tag |
| disp_age | input | AGE_W | Age stamp, smaller is older |
| bc_valid | input | NUM_BC | Valid bit per broadcast bus |
| bc_tag | input | NUM_BC*TAG_W | Tag per broadcast bus, bus k at bits k*TAG_W upward |
| iss_valid | output | NUM_FU | Issue valid per unit |
| iss_dst | output | NUM_FU*TAG_W | Issued destination tag, unit f at bits f*TAG_W upward |
| iss_src0 | output | NUM_FU*TAG_W | Issued first source tag |
| iss_src1 | output | NUM_FU*TAG_W | Issued second source tag |
| iss_age | output | NUM_FU*AGE_W | Issued age stamp, unit f at bits f*AGE_W upward |
| win_full | output | 1 | All slots occupied |

## Verification
A lone ready instruction shows the dispatch-to-issue latency. The wakeup cases are a split wakeup, a broadcast with its valid bit low, and a broadcast in the same cycle as dispatch. Together they separate a stored ready bit, a same-cycle hit, a per-bus qualifier and capture at allocation. A producer and consumer pair separates the feedback of issued tags from a design that only wakes through the external buses. The main sweep fills the window with sixteen stalled entries whose ages form a permutation, then releases them all with one broadcast. The expected age and slot on each unit in each drain cycle come from the modular inverse of the permutation step. This exposes errors in oldest-first order, unit order, full detection and the dropping of a dispatch while full.

// File: rtl/iw_pkg.sv
package iw_pkg;

    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_READY = 2'd2
    } ent_state_e;

    // Number of 4-input levels needed to cover n leaves (at least one).
    function automatic int unsigned tree_levels(input int unsigned n);
        int unsigned lv;
        int unsigned span;
        lv   = 1;
        span = 4;
        for (int j = 0; j < 15; j++) begin
            if (span < n) begin
                span = span * 4;
                lv   = lv + 1;
            end
        end
        return lv;
    endfunction

    // Start index of a level in the flat node array (level 0 = leaves).
    function automatic int unsigned level_offset(input int unsigned leaves,
                                                 input int unsigned lvl);
        int unsigned off;
        int unsigned cnt;
        off = 0;
        cnt = leaves;
        for (int unsigned j = 0; j < lvl; j++) begin
            off = off + cnt;
            cnt = cnt / 4;
        end
        return off;
    endfunction

endpackage

// File: rtl/iw_entry.sv
module iw_entry
    import iw_pkg::*;
#(
    parameter int unsigned TAG_W = 7,
    parameter int unsigned AGE_W = 8,
    parameter int unsigned NWK   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc,
    input  logic [TAG_W-1:0]       in_src0,
    input  logic                   in_rdy0,
    input  logic [TAG_W-1:0]       in_src1,
    input  logic                   in_rdy1,
    input  logic [TAG_W-1:0]       in_dst,
    input  logic [AGE_W-1:0]       in_age,
    input  logic [NWK-1:0]         wk_vld,
    input  logic [NWK*TAG_W-1:0]   wk_tag,
    input  logic                   gnt,
    output logic                   busy,
    output logic                   req,
    output logic [TAG_W-1:0]       q_src0,
    output logic [TAG_W-1:0]       q_src1,
    output logic [TAG_W-1:0]       q_dst,
    output logic [AGE_W-1:0]       q_age
);

    ent_state_e state_q, state_d;
    logic rdy0_q, rdy1_q;
    logic [TAG_W-1:0] cmp0, cmp1;
    logic hit0, hit1;
    logic eff0, eff1;

    // A free slot compares the incoming tags so a same-cycle broadcast is kept.
    always_comb begin
        cmp0 = (state_q == ENT_FREE) ? in_src0 : q_src0;
        cmp1 = (state_q == ENT_FREE) ? in_src1 : q_src1;
        hit0 = 1'b0;
        hit1 = 1'b0;
        for (int k = 0; k < NWK; k++) begin
            if (wk_vld[k] && (wk_tag[k*TAG_W +: TAG_W] == cmp0)) hit0 = 1'b1;
            if (wk_vld[k] && (wk_tag[k*TAG_W +: TAG_W] == cmp1)) hit1 = 1'b1;
        end
        eff0 = rdy0_q | hit0;
        eff1 = rdy1_q | hit1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: begin
                if (alloc)
                    state_d = ((in_rdy0 | hit0) && (in_rdy1 | hit1)) ? ENT_READY : ENT_WAIT;
            end
            ENT_WAIT: begin
                if (gnt)
                    state_d = ENT_FREE;
                else if (eff0 && eff1)
                    state_d = ENT_READY;
            end
            ENT_READY: begin
                if (gnt)
                    state_d = ENT_FREE;
            end
            default: state_d = ENT_FREE;
        endcase
    end

    // State register and operand storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
            rdy0_q  <= 1'b0;
            rdy1_q  <= 1'b0;
            q_src0  <= '0;
            q_src1  <= '0;
            q_dst   <= '0;
            q_age   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ENT_FREE) begin
                if (alloc) begin
                    rdy0_q <= in_rdy0 | hit0;
                    rdy1_q <= in_rdy1 | hit1;
                    q_src0 <= in_src0;
                    q_src1 <= in_src1;
                    q_dst  <= in_dst;
                    q_age  <= in_age;
                end
            end else begin
                rdy0_q <= eff0;
                rdy1_q <= eff1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q != ENT_FREE);
        req  = busy && eff0 && eff1;
    end

    assert_grant_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> req);

    assert_alloc_into_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (state_q == ENT_FREE));

    assert_ready_is_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_READY && !gnt) |=> (state_q == ENT_READY));

endmodule

// File: rtl/iw_arb4.sv
module iw_arb4 #(
    parameter int unsigned AGE_W = 8
) (
    input  logic [3:0]         req,
    input  logic [4*AGE_W-1:0] age,
    input  logic               gnt_in,
    output logic               any,
    output logic [AGE_W-1:0]   out_age,
    output logic [3:0]         gnt_out
);

    logic [1:0] sel;

    // Strict less-than keeps the lower child on equal ages.
    always_comb begin
        any     = 1'b0;
        out_age = '0;
        sel     = 2'd0;
        for (int k = 0; k < 4; k++) begin
            if (req[k] && (!any || (age[k*AGE_W +: AGE_W] < out_age))) begin
                any     = 1'b1;
                out_age = age[k*AGE_W +: AGE_W];
                sel     = 2'(k);
            end
        end
        gnt_out = (gnt_in && any) ? (4'b0001 << sel) : 4'b0000;
    end

endmodule

// File: rtl/iw_select.sv
module iw_select
    import iw_pkg::*;
#(
    parameter int unsigned N     = 16,
    parameter int unsigned AGE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       req,
    input  logic [N*AGE_W-1:0] age,
    output logic [N-1:0]       gnt
);

    localparam int unsigned LVLS   = tree_levels(N);
    localparam int unsigned LEAVES = 1 << (2 * LVLS);
    localparam int unsigned ROOT   = level_offset(LEAVES, LVLS);
    localparam int unsigned NODES  = ROOT + 1;

    logic             n_req [NODES];
    logic [AGE_W-1:0] n_age [NODES];
    logic             n_gnt [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign n_req[i] = req[i];
            assign n_age[i] = age[i*AGE_W +: AGE_W];
            assign gnt[i]   = n_gnt[i];
        end else begin : g_pad
            assign n_req[i] = 1'b0;
            assign n_age[i] = '0;
        end
    end

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int unsigned CNT     = LEAVES >> (2 * (l + 1));
        localparam int unsigned IN_OFF  = level_offset(LEAVES, l);
        localparam int unsigned OUT_OFF = level_offset(LEAVES, l + 1);
        for (genvar c = 0; c < CNT; c++) begin : g_cell
            logic [3:0] g4;
            iw_arb4 #(.AGE_W(AGE_W)) u_cell (
                .req     ({n_req[IN_OFF+4*c+3], n_req[IN_OFF+4*c+2],
                           n_req[IN_OFF+4*c+1], n_req[IN_OFF+4*c]}),
                .age     ({n_age[IN_OFF+4*c+3], n_age[IN_OFF+4*c+2],
                           n_age[IN_OFF+4*c+1], n_age[IN_OFF+4*c]}),
                .gnt_in  (n_gnt[OUT_OFF+c]),
                .any     (n_req[OUT_OFF+c]),
                .out_age (n_age[OUT_OFF+c]),
                .gnt_out (g4)
            );
            for (genvar k = 0; k < 4; k++) begin : g_down
                assign n_gnt[IN_OFF+4*c+k] = g4[k];
            end
        end
    end

    // The root grants whenever any request reached it.
    assign n_gnt[ROOT] = n_req[ROOT];

    assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_work_conserving_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_grant_only_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[i] |-> req[i]);
        for (genvar j = 0; j < N; j++) begin : g_pair
            if (i != j) begin : g_ne
                assert_oldest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (gnt[i] && req[j]) |-> (age[i*AGE_W +: AGE_W] <= age[j*AGE_W +: AGE_W]));
            end
        end
    end

endmodule

// File: rtl/issue_window.sv
module issue_window
    import iw_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned NUM_FU  = 2,
    parameter int unsigned NUM_BC  = 2,
    parameter int unsigned TAG_W   = 7,
    parameter int unsigned AGE_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    disp_valid,
    input  logic [TAG_W-1:0]        disp_src0,
    input  logic                    disp_rdy0,
    input  logic [TAG_W-1:0]        disp_src1,
    input  logic                    disp_rdy1,
    input  logic [TAG_W-1:0]        disp_dst,
    input  logic [AGE_W-1:0]        disp_age,
    input  logic [NUM_BC-1:0]       bc_valid,
    input  logic [NUM_BC*TAG_W-1:0] bc_tag,
    output logic [NUM_FU-1:0]       iss_valid,
    output logic [NUM_FU*TAG_W-1:0] iss_dst,
    output logic [NUM_FU*TAG_W-1:0] iss_src0,
    output logic [NUM_FU*TAG_W-1:0] iss_src1,
    output logic [NUM_FU*AGE_W-1:0] iss_age,
    output logic                    win_full
);

    localparam int unsigned NWK = NUM_BC + NUM_FU;

    logic [ENTRIES-1:0]       busy;
    logic [ENTRIES-1:0]       req;
    logic [ENTRIES-1:0]       alloc_vec;
    logic [ENTRIES-1:0]       gnt_any;
    logic [ENTRIES*AGE_W-1:0] age_flat;
    logic [TAG_W-1:0]         e_src0 [ENTRIES];
    logic [TAG_W-1:0]         e_src1 [ENTRIES];
    logic [TAG_W-1:0]         e_dst  [ENTRIES];
    logic [AGE_W-1:0]         e_age  [ENTRIES];

    logic [ENTRIES-1:0]       req_chain [NUM_FU+1];
    logic [ENTRIES-1:0]       gnt_fu    [NUM_FU];
    logic [NUM_FU-1:0]        gnt_col   [ENTRIES];

    logic [NWK-1:0]           wk_vld;
    logic [NWK*TAG_W-1:0]     wk_tag;

    // Issued tags are extra wakeup buses in the cycle they are visible.
    assign wk_vld = {iss_valid, bc_valid};
    assign wk_tag = {iss_dst, bc_tag};

    assign win_full = &busy;

    // Lowest free slot takes the dispatch.
    always_comb begin
        logic taken;
        taken     = 1'b0;
        alloc_vec = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!busy[i] && !taken) begin
                alloc_vec[i] = disp_valid;
                taken        = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        iw_entry #(.TAG_W(TAG_W), .AGE_W(AGE_W), .NWK(NWK)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc   (alloc_vec[i]),
            .in_src0 (disp_src0),
            .in_rdy0 (disp_rdy0),
            .in_src1 (disp_src1),
            .in_rdy1 (disp_rdy1),
            .in_dst  (disp_dst),
            .in_age  (disp_age),
            .wk_vld  (wk_vld),
            .wk_tag  (wk_tag),
            .gnt     (gnt_any[i]),
            .busy    (busy[i]),
            .req     (req[i]),
            .q_src0  (e_src0[i]),
            .q_src1  (e_src1[i]),
            .q_dst   (e_dst[i]),
            .q_age   (e_age[i])
        );
        assign age_flat[i*AGE_W +: AGE_W] = e_age[i];
    end

    // One select tree per unit; later units see earlier grants removed.
    assign req_chain[0] = req;
    for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
        iw_select #(.N(ENTRIES), .AGE_W(AGE_W)) u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_chain[f]),
            .age   (age_flat),
            .gnt   (gnt_fu[f])
        );
        assign req_chain[f+1] = req_chain[f] & ~gnt_fu[f];
    end

    always_comb begin
        gnt_any = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int f = 0; f < NUM_FU; f++) begin
                gnt_col[i][f] = gnt_fu[f][i];
            end
            gnt_any[i] = |gnt_col[i];
        end
    end

    // Contents of the granted entry per unit (grant vectors are one-hot).
    logic [TAG_W-1:0] nx_dst  [NUM_FU];
    logic [TAG_W-1:0] nx_src0 [NUM_FU];
    logic [TAG_W-1:0] nx_src1 [NUM_FU];
    logic [AGE_W-1:0] nx_age  [NUM_FU];

    always_comb begin
        for (int f = 0; f < NUM_FU; f++) begin
            nx_dst[f]  = '0;
            nx_src0[f] = '0;
            nx_src1[f] = '0;
            nx_age[f]  = '0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (gnt_fu[f][i]) begin
                    nx_dst[f]  = nx_dst[f]  | e_dst[i];
                    nx_src0[f] = nx_src0[f] | e_src0[i];
                    nx_src1[f] = nx_src1[f] | e_src1[i];
                    nx_age[f]  = nx_age[f]  | e_age[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= '0;
            iss_dst   <= '0;
            iss_src0  <= '0;
            iss_src1  <= '0;
            iss_age   <= '0;
        end else begin
            for (int f = 0; f < NUM_FU; f++) begin
                iss_valid[f]                 <= |gnt_fu[f];
                iss_dst[f*TAG_W +: TAG_W]    <= nx_dst[f];
                iss_src0[f*TAG_W +: TAG_W]   <= nx_src0[f];
                iss_src1[f*TAG_W +: TAG_W]   <= nx_src1[f];
                iss_age[f*AGE_W +: AGE_W]    <= nx_age[f];
            end
        end
    end

    assert_full_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_full |=> ($countones(busy) <= $past($countones(busy))));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent_chk
        assert_issue_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_any[i] |=> !busy[i]);
        assert_single_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_col[i]));
    end

    for (genvar f = 0; f < NUM_FU; f++) begin : g_fu_chk
        assert_grant_to_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (|gnt_fu[f]) |=> iss_valid[f]);
        assert_idle_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(|gnt_fu[f]) |=> !iss_valid[f]);
        if (f > 0) begin : g_order
            assert_unit_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[f] |-> (iss_valid[f-1] &&
                    (iss_age[(f-1)*AGE_W +: AGE_W] <= iss_age[f*AGE_W +: AGE_W])));
        end
    end

endmodule

// File: tb/issue_window_test.sv
module issue_window_test;

    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 7;
    localparam int AGE_W = 8;
    localparam int NFU   = 2;
    localparam int NBC   = 2;
    localparam int NENT  = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  disp_valid = 1'b0;
    logic [TAG_W-1:0]      disp_src0 = '0, disp_src1 = '0, disp_dst = '0;
    logic                  disp_rdy0 = 1'b0, disp_rdy1 = 1'b0;
    logic [AGE_W-1:0]      disp_age = '0;
    logic [NBC-1:0]        bc_valid = '0;
    logic [NBC*TAG_W-1:0]  bc_tag = '0;
    logic [NFU-1:0]        iss_valid;
    logic [NFU*TAG_W-1:0]  iss_dst, iss_src0, iss_src1;
    logic [NFU*AGE_W-1:0]  iss_age;
    logic                  win_full;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    issue_window #(.ENTRIES(NENT), .NUM_FU(NFU), .NUM_BC(NBC),
                   .TAG_W(TAG_W), .AGE_W(AGE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_src0(disp_src0), .disp_rdy0(disp_rdy0),
        .disp_src1(disp_src1), .disp_rdy1(disp_rdy1), .disp_dst(disp_dst),
        .disp_age(disp_age), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src0(iss_src0),
        .iss_src1(iss_src1), .iss_age(iss_age), .win_full(win_full)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put(input int s0, input bit r0, input int s1, input bit r1,
                       input int dst, input int age);
        disp_valid = 1'b1;
        disp_src0  = TAG_W'(s0);
        disp_rdy0  = r0;
        disp_src1  = TAG_W'(s1);
        disp_rdy1  = r1;
        disp_dst   = TAG_W'(dst);
        disp_age   = AGE_W'(age);
    endtask

    task automatic unput();
        disp_valid = 1'b0;
    endtask

    task automatic bcast(input int bus, input bit v, input int tag);
        bc_valid[bus]              = v;
        bc_tag[bus*TAG_W +: TAG_W] = TAG_W'(tag);
    endtask

    function automatic int dst_of(input int f);
        return int'(iss_dst[f*TAG_W +: TAG_W]);
    endfunction

    function automatic int age_of(input int f);
        return int'(iss_age[f*AGE_W +: AGE_W]);
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        chk("R1", "iss_valid in reset", int'(iss_valid), 0);
        chk("R1", "win_full in reset", int'(win_full), 0);
        rst_n = 1'b1;
        step();
        chk("R1", "iss_valid after reset", int'(iss_valid), 0);
        chk("R1", "win_full after reset", int'(win_full), 0);

        // R2: lone ready instruction
        put(1, 1, 2, 1, 10, 5);
        step();
        unput();
        chk("R2", "no issue one edge after dispatch", int'(iss_valid), 0);
        step();
        chk("R2", "issue valid", int'(iss_valid), 1);
        chk("R2", "issue dst", dst_of(0), 10);
        chk("R2", "issue src0", int'(iss_src0[0 +: TAG_W]), 1);
        chk("R2", "issue src1", int'(iss_src1[0 +: TAG_W]), 2);
        chk("R2", "issue age", age_of(0), 5);
        step();
        chk("R2", "not issued again", int'(iss_valid), 0);

        // R3 / R4: split wakeup, invalid bus ignored
        put(20, 0, 21, 0, 30, 6);
        step();
        unput();
        bcast(0, 1, 20);
        step();
        chk("R4", "one source ready, no issue", int'(iss_valid), 0);
        bcast(0, 0, 20);
        bcast(1, 0, 21);
        step();
        chk("R3", "invalid bus tag ignored", int'(iss_valid), 0);
        bcast(1, 1, 21);
        step();
        bcast(1, 0, 0);
        chk("R3", "issue after second source", int'(iss_valid), 1);
        chk("R3", "issued dst", dst_of(0), 30);
        step();
        chk("R3", "idle after wakeup issue", int'(iss_valid), 0);

        // R5: broadcast coinciding with dispatch
        put(40, 0, 41, 1, 42, 7);
        bcast(0, 1, 40);
        step();
        unput();
        bcast(0, 0, 0);
        chk("R5", "no issue one edge after dispatch", int'(iss_valid), 0);
        step();
        chk("R5", "captured wakeup issues", int'(iss_valid), 1);
        chk("R5", "issued dst", dst_of(0), 42);
        step();

        // R8: back-to-back producer / consumer
        put(70, 1, 71, 1, 50, 1);
        step();
        put(50, 0, 72, 1, 51, 2);
        step();
        unput();
        chk("R8", "producer issued", int'(iss_valid), 1);
        chk("R8", "producer dst", dst_of(0), 50);
        step();
        chk("R8", "consumer issued next cycle", int'(iss_valid), 1);
        chk("R8", "consumer dst", dst_of(0), 51);
        step();
        chk("R8", "idle after chain", int'(iss_valid), 0);

        // R6 / R7 / R9: fill with stalled entries, permuted ages
        for (int i = 0; i < NENT; i++) begin
            chk("R9", "not full while filling", int'(win_full), 0);
            put(60, 0, 61, 1, 80 + i, ((i * 5) % 16) + 1);
            step();
        end
        unput();
        chk("R9", "full after sixteen", int'(win_full), 1);
        chk("R4", "stalled entries do not issue", int'(iss_valid), 0);
        put(63, 1, 64, 1, 120, 0);
        step();
        unput();
        chk("R9", "still full", int'(win_full), 1);
        chk("R9", "dispatch while full did not issue", int'(iss_valid), 0);
        bcast(0, 1, 60);
        step();
        bcast(0, 0, 0);
        chk("R9", "slots freed by issue", int'(win_full), 0);
        for (int k = 0; k < 8; k++) begin
            chk("R6", $sformatf("both units busy cycle %0d", k), int'(iss_valid), 3);
            chk("R7", $sformatf("unit0 age cycle %0d", k), age_of(0), 2 * k + 1);
            chk("R7", $sformatf("unit1 age cycle %0d", k), age_of(1), 2 * k + 2);
            chk("R7", $sformatf("unit0 slot cycle %0d", k), dst_of(0), 80 + (((2 * k) * 13) % 16));
            chk("R7", $sformatf("unit1 slot cycle %0d", k), dst_of(1), 80 + (((2 * k + 1) * 13) % 16));
            step();
        end
        chk("R9", "dropped dispatch never issues", int'(iss_valid), 0);
        chk("R9", "empty after drain", int'(win_full), 0);
        step();
        chk("R9", "still idle", int'(iss_valid), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule